// File: doc/BRIEF.md
# Erase-Block Write-Protect Lock Controller

This block holds a three-state protection flag for every erase block of a flash array. Each block is either locked, unlocked or lock-tight. Four commands change the flags: range unlock, range lock, range lock-tight and unlock-all. The range commands work over an inclusive start/end block range that is held in two registers. A command walks its range one block per clock and ends with a single-cycle done pulse.

A status output always shows the state most recently written into any block. A sticky error flag reports a sweep that reached a block index at or beyond the block count. A combinational query port returns the flag of any block, so that the program and erase paths can be gated on it.

The range registers are written through a 16-bit data bus with two write strobes. They keep the low `IDX_W = clog2(NUM_BLOCKS)` bits of the written value, which is the value masked with `2^IDX_W - 1`. When `NUM_BLOCKS` is not a power of two, a range can therefore point past the last block. The default of 48 blocks leaves indices 48 to 63 out of range.

Top module: `wpl_lock_ctrl`

## Requirements
- R1: A cold reset (`rstN` low) sets every block to locked, sets the status to locked, clears the error flag and leaves the block idle.
- R2: States are one-hot in 3 bits: lock-tight = 3'b001, locked = 3'b010, unlocked = 3'b100. The opcodes are 8'h23 range unlock, 8'h27 unlock-all, 8'h2A range lock and 8'h2C range lock-tight.
- R3: A start-register write loads both the start and the end register with `regData` masked to `IDX_W` bits. An end-register write changes only the end register, and it wins over a start write in the same cycle.
- R4: Range unlock and range lock visit blocks from start to end inclusive, one per clock, with `busy` high for exactly the number of blocks visited. `done` is high for one cycle, in the cycle after the last visit.
- R5: A range-unlock, range-lock or unlock-all sweep stops at the first block that is lock-tight. That block is counted as visited, it is left unchanged and no error is raised.
- R6: Lock-tight leaves blocks that are unlocked untouched and carries on with the next block. Every other block in the range becomes lock-tight, and no command clears lock-tight except a cold reset.
- R7: A visited index at or above `NUM_BLOCKS` sets `cmdErr` and ends the sweep. The flag is cleared when the next command is accepted.
- R8: `wpStatus` takes the new state of every block that is written. It keeps its value when a command writes no block.
- R9: Unlock-all applies the unlock rule from block 0 to block `NUM_BLOCKS-1`, ignoring the range registers.
- R10: A warm reset (`warmRst` high at a clock edge) leaves the table unchanged. It sets the status to locked, clears the error flag and zeroes both range registers.
- R11: A range command with start greater than end gives a `done` pulse with no busy cycle and no block change. An opcode other than the four is ignored, and so is a command that arrives while `busy` is high.
- R12: `qryState` returns the state of block `qryIdx`, and `qryWritable` is high only when that state is unlocked. An index at or above `NUM_BLOCKS` reads as locked and not writable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous cold reset, active low |
| warmRst | input | 1 | Synchronous warm reset, active high |
| startWe | input | 1 | Write strobe for the start-block register (also loads the end register) |
| endWe | input | 1 | Write strobe for the end-block register |
| regData | input | 16 | Write data for the range registers |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 8 | Command opcode |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse at the end of a command |
| wpStatus | output | 3 | Most recently written block state |
| cmdErr | output | 1 | Sticky out-of-range error flag |
| qryIdx | input | IDX_W | Block index to query |
| qryState | output | 3 | State of the queried block |
| qryWritable | output | 1 | Queried block may be programmed or erased |

## Verification
The bench goes after the abort rules. A range unlock and an unlock-all that run into a lock-tight block must stop there. A design that skipped over that block instead would unlock blocks beyond it, and the table scan shows them. A lock-tight sweep across unlocked blocks must leave both those blocks and the status alone. A design that promoted them, or updated the status on a skip, gives a different table or status.

Ranges that run past the block count, or that start beyond it, must visit exactly the in-range blocks plus one error visit. A wrong bound shows up in the busy-cycle count or in the error flag. An inverted range, an unknown opcode and a command issued mid-sweep must cause no change. A warm reset must keep the lock-tight blocks while zeroing the range.

// File: rtl/wpl_pkg.sv
package wpl_pkg;

  // one-hot block protection states (R2)
  localparam logic [2:0] ST_TIGHT  = 3'b001;
  localparam logic [2:0] ST_LOCKED = 3'b010;
  localparam logic [2:0] ST_OPEN   = 3'b100;

  // accepted opcodes (R2)
  localparam logic [7:0] OPC_UNLOCK     = 8'h23;
  localparam logic [7:0] OPC_UNLOCK_ALL = 8'h27;
  localparam logic [7:0] OPC_LOCK       = 8'h2A;
  localparam logic [7:0] OPC_TIGHT      = 8'h2C;

  typedef enum logic [1:0] {
    OP_OPEN  = 2'd0,
    OP_LOCK  = 2'd1,
    OP_TIGHT = 2'd2
  } sweep_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      act;     // visit the current index this cycle
    logic      clrErr;  // a new command was accepted
    sweep_op_e op;
  } sweep_strb_t;

endpackage

// File: rtl/wpl_ctrl.sv
module wpl_ctrl
  import wpl_pkg::*;
#(
  parameter int NUM_BLOCKS = 48,
  parameter int IDX_W      = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             warmRst,
  input  logic             startWe,
  input  logic             endWe,
  input  logic [15:0]      regData,
  input  logic             cmdValid,
  input  logic [7:0]       cmdCode,
  input  logic             stopNow,
  output sweep_strb_t      strb,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_BLK = IDX_W'(NUM_BLOCKS - 1);

  typedef enum logic {S_IDLE, S_SWEEP} ctrl_state_e;

  ctrl_state_e      state;
  logic [IDX_W-1:0] startReg, endReg, lastIdx;
  sweep_op_e        opReg;

  logic      known, isAll, accept, empty;
  sweep_op_e opDec;

  always_comb begin
    known = 1'b1;
    isAll = 1'b0;
    opDec = OP_OPEN;
    unique case (cmdCode)
      OPC_UNLOCK:     opDec = OP_OPEN;
      OPC_UNLOCK_ALL: begin opDec = OP_OPEN; isAll = 1'b1; end
      OPC_LOCK:       opDec = OP_LOCK;
      OPC_TIGHT:      opDec = OP_TIGHT;
      default:        known = 1'b0;
    endcase
  end

  assign busy   = (state == S_SWEEP);
  assign accept = cmdValid && known && !busy;
  assign empty  = !isAll && (startReg > endReg);

  always_comb begin
    strb.act    = busy;
    strb.clrErr = accept;
    strb.op     = opReg;
  end

  // range registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startReg <= '0;
      endReg   <= '0;
    end else if (warmRst) begin
      startReg <= '0;
      endReg   <= '0;
    end else begin
      if (startWe) begin
        startReg <= regData[IDX_W-1:0];
        endReg   <= regData[IDX_W-1:0];
      end
      if (endWe) endReg <= regData[IDX_W-1:0];
    end
  end

  // sweep sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      idx     <= '0;
      lastIdx <= '0;
      opReg   <= OP_OPEN;
      done    <= 1'b0;
    end else if (warmRst) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        opReg   <= opDec;
        idx     <= isAll ? '0 : startReg;
        lastIdx <= isAll ? LAST_BLK : endReg;
        if (empty) done  <= 1'b1;
        else       state <= S_SWEEP;
      end else if (busy) begin
        if (stopNow || idx == lastIdx) begin
          state <= S_IDLE;
          done  <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R4
  sweep_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && idx == lastIdx) |=> !busy);
  // R11
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid && !warmRst) |=> (busy || done) && opReg == $past(opReg));

endmodule

// File: rtl/wpl_table.sv
module wpl_table
  import wpl_pkg::*;
#(
  parameter int NUM_BLOCKS = 48,
  parameter int IDX_W      = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             warmRst,
  input  sweep_strb_t      strb,
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] qryIdx,
  output logic             stopNow,
  output logic [2:0]       wpStatus,
  output logic             cmdErr,
  output logic [2:0]       qryState
);

  localparam logic [IDX_W:0] NB_W = (IDX_W+1)'(NUM_BLOCKS);

  logic [2:0] tbl [NUM_BLOCKS];
  logic [2:0] curState, newState;
  logic       inRange, abortTight, skipOpen, writeEn;

  assign inRange = {1'b0, idx} < NB_W;

  // read mux for the sweep index
  always_comb begin
    curState = ST_LOCKED;
    for (int b = 0; b < NUM_BLOCKS; b++)
      if (idx == IDX_W'(b)) curState = tbl[b];
  end

  // read mux for the query port; out-of-range reads as locked
  always_comb begin
    qryState = ST_LOCKED;
    for (int b = 0; b < NUM_BLOCKS; b++)
      if (qryIdx == IDX_W'(b)) qryState = tbl[b];
  end

  always_comb begin
    unique case (strb.op)
      OP_LOCK:  newState = ST_LOCKED;
      OP_TIGHT: newState = ST_TIGHT;
      default:  newState = ST_OPEN;
    endcase
  end

  assign abortTight = (strb.op != OP_TIGHT) && (curState == ST_TIGHT);
  assign skipOpen   = (strb.op == OP_TIGHT) && (curState == ST_OPEN);
  assign stopNow    = strb.act && (!inRange || abortTight);
  assign writeEn    = strb.act && inRange && !abortTight && !skipOpen;

  // the table survives a warm reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BLOCKS; b++) tbl[b] <= ST_LOCKED;
    end else if (writeEn && !warmRst) begin
      for (int b = 0; b < NUM_BLOCKS; b++)
        if (idx == IDX_W'(b)) tbl[b] <= newState;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wpStatus <= ST_LOCKED;
      cmdErr   <= 1'b0;
    end else if (warmRst) begin
      wpStatus <= ST_LOCKED;
      cmdErr   <= 1'b0;
    end else begin
      if (strb.clrErr)                 cmdErr <= 1'b0;
      else if (strb.act && !inRange)   cmdErr <= 1'b1;
      if (writeEn) wpStatus <= newState;
    end
  end

  // R2
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(wpStatus));
  // R6
  tight_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(qryState) == ST_TIGHT && qryIdx == $past(qryIdx)) |-> qryState == ST_TIGHT);
  // R7
  range_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.act && !inRange && !warmRst) |=> cmdErr);
  // R7
  err_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdErr) |-> $past(strb.act));

endmodule

// File: rtl/wpl_lock_ctrl.sv
module wpl_lock_ctrl
  import wpl_pkg::*;
#(
  parameter  int NUM_BLOCKS = 48,
  localparam int IDX_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             warmRst,
  input  logic             startWe,
  input  logic             endWe,
  input  logic [15:0]      regData,
  input  logic             cmdValid,
  input  logic [7:0]       cmdCode,
  output logic             busy,
  output logic             done,
  output logic [2:0]       wpStatus,
  output logic             cmdErr,
  input  logic [IDX_W-1:0] qryIdx,
  output logic [2:0]       qryState,
  output logic             qryWritable
);

  sweep_strb_t      strb;
  logic [IDX_W-1:0] idx;
  logic             stopNow;

  wpl_ctrl #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .warmRst(warmRst),
    .startWe(startWe), .endWe(endWe), .regData(regData),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .stopNow(stopNow),
    .strb(strb), .idx(idx), .busy(busy), .done(done)
  );

  wpl_table #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rstN(rstN), .warmRst(warmRst),
    .strb(strb), .idx(idx), .qryIdx(qryIdx),
    .stopNow(stopNow), .wpStatus(wpStatus), .cmdErr(cmdErr),
    .qryState(qryState)
  );

  assign qryWritable = (qryState == ST_OPEN);

  // R12
  writable_chk: assert property (@(posedge clk) disable iff (!rstN)
    qryWritable |-> $onehot(qryState) && qryState[2]);

endmodule

// File: tb/tb_wpl_lock_ctrl.sv
module tb_wpl_lock_ctrl;
  import wpl_pkg::*;

  localparam int NB = 48;
  localparam int IW = $clog2(NB);
  localparam int MASK = (1 << IW) - 1;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, warmRst = 1'b0;
  logic startWe = 1'b0, endWe = 1'b0, cmdValid = 1'b0;
  logic [15:0] regData = '0;
  logic [7:0] cmdCode = '0;
  logic busy, done, cmdErr, qryWritable;
  logic [2:0] wpStatus, qryState;
  logic [IW-1:0] qryIdx = '0;

  wpl_lock_ctrl #(.NUM_BLOCKS(NB)) dut (
    .clk(clk), .rstN(rstN), .warmRst(warmRst), .startWe(startWe), .endWe(endWe),
    .regData(regData), .cmdValid(cmdValid), .cmdCode(cmdCode), .busy(busy),
    .done(done), .wpStatus(wpStatus), .cmdErr(cmdErr), .qryIdx(qryIdx),
    .qryState(qryState), .qryWritable(qryWritable)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [2:0] st; logic err; string tag; } exp_t;
  exp_t expQ[$];

  int vectors = 0, miscompares = 0, doneCount = 0;
  bit finished = 0;
  logic [2:0] model [NB];
  logic [2:0] mStatus;
  logic mErr;
  int mStart, mEnd;

  task automatic check(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && done) begin
      doneCount++;
      if (expQ.size() == 0) begin
        check(0, "R11", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(wpStatus == e.st, e.tag, "wpStatus", int'(wpStatus), int'(e.st));
        check(cmdErr == e.err, e.tag, "cmdErr", int'(cmdErr), int'(e.err));
      end
    end
  end

  task automatic writeStart(int v);
    @(negedge clk); regData = 16'(v); startWe = 1'b1;
    @(negedge clk); startWe = 1'b0;
    mStart = v & MASK; mEnd = mStart;
  endtask

  task automatic writeEnd(int v);
    @(negedge clk); regData = 16'(v); endWe = 1'b1;
    @(negedge clk); endWe = 1'b0;
    mEnd = v & MASK;
  endtask

  // model of one command; returns number of visited blocks
  function automatic int modelCmd(logic [7:0] code);
    int s, e, visits;
    logic [2:0] ns;
    s = (code == OPC_UNLOCK_ALL) ? 0 : mStart;
    e = (code == OPC_UNLOCK_ALL) ? NB - 1 : mEnd;
    ns = (code == OPC_LOCK) ? ST_LOCKED : (code == OPC_TIGHT) ? ST_TIGHT : ST_OPEN;
    mErr = 1'b0;
    visits = 0;
    for (int b = s; b <= e; b++) begin
      visits++;
      if (b >= NB) begin mErr = 1'b1; break; end
      if (code != OPC_TIGHT && model[b] == ST_TIGHT) break;
      if (code == OPC_TIGHT && model[b] == ST_OPEN) continue;
      model[b] = ns;
      mStatus = ns;
    end
    return visits;
  endfunction

  task automatic runCmd(logic [7:0] code, string tag, bit inject);
    int visits, busyCycles, guard;
    exp_t e;
    visits = modelCmd(code);
    e.st = mStatus; e.err = mErr; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk); cmdValid = 1'b1; cmdCode = code;
    @(negedge clk); cmdValid = 1'b0;
    busyCycles = 0; guard = 0;
    while (busy && guard < 500) begin
      busyCycles++; guard++;
      if (inject && busyCycles == 1) begin cmdValid = 1'b1; cmdCode = OPC_TIGHT; end
      @(negedge clk);
      cmdValid = 1'b0;
    end
    check(busyCycles == visits, tag, "busy cycles", busyCycles, visits);
    check(done == 1'b1, tag, "done after sweep", int'(done), 1);
  endtask

  task automatic checkTable(string tag);
    int bad = 0;
    for (int b = 0; b < NB; b++) begin
      qryIdx = IW'(b); #1;
      if (qryState !== model[b] || qryWritable !== (model[b] == ST_OPEN)) begin
        bad++;
        $display("FAIL %s block %0d: actual %0h expected %0h", tag, b, qryState, model[b]);
      end
    end
    vectors++;
    if (bad != 0) miscompares++;
  endtask

  task automatic coldReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int b = 0; b < NB; b++) model[b] = ST_LOCKED;
    mStatus = ST_LOCKED; mErr = 1'b0; mStart = 0; mEnd = 0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    vectors++; miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    int dc;
    coldReset();
    @(negedge clk);
    // R1 reset state
    check(wpStatus == ST_LOCKED, "R1", "status after reset", int'(wpStatus), int'(ST_LOCKED));
    check(cmdErr == 1'b0, "R1", "err after reset", int'(cmdErr), 0);
    check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    checkTable("R1");

    // R3 start write copies into end: single block unlock
    writeStart(5);
    runCmd(OPC_UNLOCK, "R3", 0);
    checkTable("R3");

    // R4 inclusive range, R2 unlock encoding
    writeStart(10); writeEnd(13);
    runCmd(OPC_UNLOCK, "R4", 0);
    checkTable("R4");

    // R8 lock-tight over only unlocked blocks writes nothing
    writeStart(11); writeEnd(12);
    runCmd(OPC_TIGHT, "R8", 0);
    checkTable("R8");

    // R6 lock-tight skips unlocked, promotes the rest
    writeStart(9); writeEnd(14);
    runCmd(OPC_TIGHT, "R6", 0);
    checkTable("R6");

    // R5 unlock stops at first lock-tight block
    writeStart(8); writeEnd(20);
    runCmd(OPC_UNLOCK, "R5", 0);
    checkTable("R5");

    // R5 lock stops at lock-tight block 9
    writeStart(0); writeEnd(47);
    runCmd(OPC_LOCK, "R5", 0);
    checkTable("R5");

    // R9 unlock-all, also stopped by block 9
    runCmd(OPC_UNLOCK_ALL, "R9", 0);
    checkTable("R9");

    // R7 range running past the block count; R3 masking of 0x128 -> 40
    writeStart(16'h0128); writeEnd(50);
    runCmd(OPC_LOCK, "R7", 0);
    checkTable("R7");

    // R7 start beyond the count (0x130 masks to 48)
    writeStart(16'h0130);
    runCmd(OPC_LOCK, "R7", 0);

    // R11 inverted range; R7 error cleared on acceptance
    writeStart(20); writeEnd(18);
    runCmd(OPC_UNLOCK, "R11", 0);
    checkTable("R11");

    // R11 unknown opcode ignored
    dc = doneCount;
    @(negedge clk); cmdValid = 1'b1; cmdCode = 8'h99;
    @(negedge clk); cmdValid = 1'b0;
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R11", "busy after unknown code", int'(busy), 0);
    check(doneCount == dc, "R11", "done after unknown code", doneCount, dc);
    checkTable("R11");

    // R11 command during a sweep ignored
    writeStart(20); writeEnd(30);
    runCmd(OPC_UNLOCK, "R11", 1);
    checkTable("R11");

    // R10 warm reset keeps table, clears range and status
    @(negedge clk); warmRst = 1'b1;
    @(negedge clk); warmRst = 1'b0;
    mStatus = ST_LOCKED; mErr = 1'b0; mStart = 0; mEnd = 0;
    check(wpStatus == ST_LOCKED, "R10", "status after warm reset", int'(wpStatus), int'(ST_LOCKED));
    checkTable("R10");
    runCmd(OPC_LOCK, "R10", 0);
    checkTable("R10");

    // R6 whole-range lock-tight then lock/unlock-all abort at block 0
    writeStart(0); writeEnd(47);
    runCmd(OPC_TIGHT, "R6", 0);
    runCmd(OPC_LOCK, "R6", 0);
    runCmd(OPC_UNLOCK_ALL, "R6", 0);
    checkTable("R6");

    // R3 end write wins over start write in the same cycle
    @(negedge clk); regData = 16'd3; startWe = 1'b1; endWe = 1'b1;
    @(negedge clk); startWe = 1'b0; endWe = 1'b0;
    mStart = 3; mEnd = 3;
    @(negedge clk); regData = 16'd2; startWe = 1'b1;
    @(negedge clk); regData = 16'd4; startWe = 1'b0; endWe = 1'b1;
    @(negedge clk); endWe = 1'b0;
    mStart = 2; mEnd = 4;
    coldReset();
    writeStart(2); writeEnd(4);
    runCmd(OPC_UNLOCK, "R3", 0);
    checkTable("R3");

    // R12 out-of-range query
    qryIdx = IW'(50); #1;
    check(qryState == ST_LOCKED, "R12", "oob query state", int'(qryState), int'(ST_LOCKED));
    check(qryWritable == 1'b0, "R12", "oob query writable", int'(qryWritable), 0);
    qryIdx = IW'(3); #1;
    check(qryWritable == 1'b1, "R12", "writable on unlocked", int'(qryWritable), 1);

    // R1 cold reset relocks everything
    coldReset();
    @(negedge clk);
    checkTable("R1");
    check(expQ.size() == 0, "R4", "pending expected items", expQ.size(), 0);

    finish();
  end

endmodule